// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block moderates the interrupt rate of one DMA channel. Instead of signalling every finished frame, it counts frame-completion pulses down from a programmable threshold and emits a completion-interrupt set pulse only when that count reaches zero. The count then restarts from the threshold. When completions stop short of the threshold, a programmable idle-delay timer still reports them. The timer restarts on each completion, ticks down on a prescaler enable, and emits a delay-interrupt set pulse when it runs out. It also reloads the completion count.

The threshold and delay come from the channel's control register, and the control-write strobe marks every write to it. The two set pulses feed a pending/mask stage that sits outside this block. The live counter and live timer values are registered outputs, so the status word can show them directly.

Top module: `irq_coalesce`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the live count equals the reset threshold (1 by default), the live timer is 0, and both set pulses are low.
- R2: A cycle with the control-write strobe high loads the live count with the threshold input in the next cycle. This overrides any completion or timer expiry in that same cycle, and no completion interrupt is raised for that cycle.
- R3: A completion that does not reach zero decrements the live count by exactly one. Without a completion, a write or an expiry, the count holds.
- R4: A completion that brings the count to zero raises the completion set pulse for exactly one cycle, and the count shows the threshold again in that same cycle.
- R5: A threshold of 0 needs 256 completions per completion interrupt, because the 8-bit count wraps from 0 to 255.
- R6: A completion while the delay input is nonzero loads the timer with the delay value in the next cycle. This holds even when the timer is already running.
- R7: A completion while the delay input is 0 leaves the timer unchanged.
- R8: The timer decrements by one only in cycles with the tick enable high and a nonzero timer value. It holds otherwise and stays at 0 once it has expired.
- R9: A tick while the timer is 1 is an expiry. The delay set pulse is high for exactly one cycle, the timer becomes 0, and the count reloads from the threshold.
- R10: When an expiry and a nonzero-delay completion fall in the same cycle, the delay set pulse is still raised and the timer takes the delay value. The count reloads from the threshold and then counts this completion, so it shows threshold minus one, or raises the completion interrupt when the threshold is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | One-cycle strobe: the control register was written |
| thresh | input | CNT_W | Completion threshold field of the control register |
| delay | input | TMR_W | Idle-delay field of the control register |
| done | input | 1 | One-cycle frame-completion pulse |
| tick_en | input | 1 | Timer prescaler enable |
| ioc_set | output | 1 | Completion-interrupt set pulse |
| dly_set | output | 1 | Delay-interrupt set pulse |
| live_count | output | CNT_W | Current completion count for status readback |
| live_timer | output | TMR_W | Current timer value for status readback |

## Verification
Timer expiry and a new completion can occur in the same clock cycle. A control write can also coincide with a completion. The bench steers the timer down to 1 and then drives a tick together with a completion, with a threshold of 1 and then a larger threshold. It checks that the delay pulse is kept, that the timer restarts from the delay value, and that the reload-then-count rule decides the count and any completion pulse. A long pseudo-random stretch of mixed strobes then compares every output with a behavioural model on every clock.

// File: rtl/irq_coalesce_pkg.sv
package irq_coalesce_pkg;
  localparam int unsigned CNT_W_DEF      = 8;
  localparam int unsigned TMR_W_DEF      = 8;
  localparam int unsigned RST_THRESH_DEF = 1;

  typedef enum logic [1:0] {
    CNT_HOLD   = 2'd0,
    CNT_LOAD   = 2'd1,
    CNT_DEC    = 2'd2,
    CNT_WRAPUP = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/coal_timer.sv
module coal_timer #(
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic             tick_en,
  input  logic [TMR_W-1:0] delay,
  output logic             expire_c,
  output logic             dly_q,
  output logic [TMR_W-1:0] tmr_q
);
  localparam logic [TMR_W-1:0] ONE  = TMR_W'(1);
  localparam logic [TMR_W-1:0] ZERO = '0;

  logic             restart;
  logic [TMR_W-1:0] tmr_d;

  assign restart  = done && (delay != ZERO);
  assign expire_c = tick_en && (tmr_q == ONE);

  always_comb begin
    tmr_d = tmr_q;
    if (restart) begin
      tmr_d = delay;
    end else if (tick_en && (tmr_q != ZERO)) begin
      tmr_d = tmr_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q <= ZERO;
      dly_q <= 1'b0;
    end else begin
      tmr_q <= tmr_d;
      dly_q <= expire_c;
    end
  end
endmodule

// File: rtl/coal_count.sv
module coal_count
  import irq_coalesce_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned RST_THRESH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             done,
  input  logic             reload,
  input  logic [CNT_W-1:0] thresh,
  output logic             ioc_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO  = '0;
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(RST_THRESH);

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] dec;
  cnt_op_e          op;
  logic [CNT_W-1:0] cnt_d;

  // An expiry reloads first; a completion is then counted from there.
  assign base = reload ? thresh : cnt_q;
  assign dec  = base - ONE;

  always_comb begin
    if (wr) begin
      op = CNT_LOAD;
    end else if (done) begin
      op = (dec == ZERO) ? CNT_WRAPUP : CNT_DEC;
    end else begin
      op = CNT_HOLD;
    end
  end

  always_comb begin
    unique case (op)
      CNT_LOAD:   cnt_d = thresh;
      CNT_WRAPUP: cnt_d = thresh;
      CNT_DEC:    cnt_d = dec;
      default:    cnt_d = base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RST_V;
      ioc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ioc_q <= (op == CNT_WRAPUP);
    end
  end
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
  import irq_coalesce_pkg::*;
#(
  parameter int unsigned CNT_W      = CNT_W_DEF,
  parameter int unsigned TMR_W      = TMR_W_DEF,
  parameter int unsigned RST_THRESH = RST_THRESH_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [CNT_W-1:0] thresh,
  input  logic [TMR_W-1:0] delay,
  input  logic             done,
  input  logic             tick_en,
  output logic             ioc_set,
  output logic             dly_set,
  output logic [CNT_W-1:0] live_count,
  output logic [TMR_W-1:0] live_timer
);
  logic expire_c;

  coal_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .tick_en  (tick_en),
    .delay    (delay),
    .expire_c (expire_c),
    .dly_q    (dly_set),
    .tmr_q    (live_timer)
  );

  coal_count #(.CNT_W(CNT_W), .RST_THRESH(RST_THRESH)) u_count (
    .clk    (clk),
    .rst    (rst),
    .wr     (ctrl_wr),
    .done   (done),
    .reload (expire_c),
    .thresh (thresh),
    .ioc_q  (ioc_set),
    .cnt_q  (live_count)
  );
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TMR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_wr,
  input logic [CNT_W-1:0] thresh,
  input logic [TMR_W-1:0] delay,
  input logic             done,
  input logic             tick_en,
  input logic             ioc_set,
  input logic             dly_set,
  input logic [CNT_W-1:0] live_count,
  input logic [TMR_W-1:0] live_timer
);
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (live_count == $past(thresh))); // R2
  AST_IOC_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    ioc_set |-> ($past(done) && !$past(ctrl_wr))); // R4
  AST_RESTART_LOADS: assert property (@(posedge clk) disable iff (rst)
    (done && (delay != '0)) |=> (live_timer == $past(delay))); // R6
  AST_TIMER_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!done && !tick_en) |=> $stable(live_timer)); // R8
  AST_DLY_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    dly_set |-> ($past(tick_en) && ($past(live_timer) == TMR_W'(1)))); // R9
endmodule

bind irq_coalesce irq_coalesce_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .thresh(thresh), .delay(delay),
  .done(done), .tick_en(tick_en), .ioc_set(ioc_set), .dly_set(dly_set),
  .live_count(live_count), .live_timer(live_timer)
);

// File: tb/irq_coalesce_bench.sv
module irq_coalesce_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ctrl_wr = 1'b0;
  logic [W-1:0] thresh = '0;
  logic [W-1:0] delay = '0;
  logic         done = 1'b0;
  logic         tick_en = 1'b0;
  logic         ioc_set, dly_set;
  logic [W-1:0] live_count, live_timer;

  int checks = 0;
  int fails = 0;
  string req = "R1";

  int m_cnt = 1, m_tmr = 0, m_ioc = 0, m_dly = 0;
  int base;
  bit expired;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_coalesce u_irq_coalesce (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .thresh(thresh), .delay(delay),
    .done(done), .tick_en(tick_en), .ioc_set(ioc_set), .dly_set(dly_set),
    .live_count(live_count), .live_timer(live_timer)
  );

  // Behavioural reference, advanced on every rising edge.
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 1; m_tmr = 0; m_ioc = 0; m_dly = 0;
    end else begin
      expired = tick_en && (m_tmr == 1);
      base = expired ? int'(thresh) : m_cnt;
      m_ioc = 0;
      if (ctrl_wr) m_cnt = int'(thresh);
      else if (done) begin
        base = (base + 255) % 256;
        if (base == 0) begin m_ioc = 1; m_cnt = int'(thresh); end
        else m_cnt = base;
      end else m_cnt = base;
      if (done && delay != 0) m_tmr = int'(delay);
      else if (tick_en && m_tmr != 0) m_tmr = m_tmr - 1;
      m_dly = expired ? 1 : 0;
    end
  end

  task automatic compare();
    checks++;
    if (int'(live_count) != m_cnt || int'(live_timer) != m_tmr ||
        int'(ioc_set) != m_ioc || int'(dly_set) != m_dly) begin
      fails++;
      $display("FAIL %s: count/timer/ioc/dly actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
               req, live_count, live_timer, ioc_set, dly_set, m_cnt, m_tmr, m_ioc, m_dly);
    end
  endtask

  task automatic step(input bit d, input bit w, input bit t);
    done = d; ctrl_wr = w; tick_en = t;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    @(negedge clk);
    req = "R1";
    step(0, 0, 0); step(0, 0, 0);
    rst = 1'b0;
    step(0, 0, 0);
    // R2 R3 R4: threshold 3
    req = "R2"; thresh = 8'd3; step(0, 1, 0);
    req = "R3"; step(1, 0, 0); step(0, 0, 0); step(1, 0, 0);
    req = "R4"; step(1, 0, 0); step(0, 0, 0);
    // R2: write beats a same-cycle completion
    req = "R2"; thresh = 8'd4; step(1, 1, 0); step(0, 0, 0);
    // R5: threshold 0 wraps
    req = "R5"; thresh = 8'd0; step(0, 1, 0);
    for (int i = 0; i < 256; i++) step(1, 0, 0);
    step(0, 0, 0);
    // R6 R7 R8 R9: timer
    req = "R6"; thresh = 8'd6; delay = 8'd5; step(0, 1, 0); step(1, 0, 0);
    req = "R8"; step(0, 0, 1); step(0, 0, 0); step(0, 0, 1);
    req = "R6"; step(1, 0, 0);
    req = "R7"; delay = 8'd0; step(1, 0, 0); step(0, 0, 0);
    req = "R9"; for (int i = 0; i < 5; i++) step(0, 0, 1);
    req = "R8"; step(0, 0, 1); step(0, 0, 1);
    // R10: coincident expiry and completion, threshold 1 then 5
    req = "R10"; thresh = 8'd1; delay = 8'd2; step(0, 1, 0); step(1, 0, 0);
    step(0, 0, 1); step(1, 0, 1); step(0, 0, 0);
    thresh = 8'd5; step(0, 1, 0); step(0, 0, 1); step(1, 0, 1); step(0, 0, 0);
    // Mixed traffic
    req = "R2/R3/R4/R6/R8/R9/R10";
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      thresh = {5'd0, lfsr[2:0]};
      delay  = {6'd0, lfsr[5:4]};
      step(lfsr[7] & lfsr[8], (lfsr[11:9] == 3'd0), lfsr[12] | lfsr[13]);
    end
    finish_run();
  end
endmodule